// File: doc/BRIEF.md
# Systolic Insertion Sorter

This block keeps a running list of unsigned keys in ascending order across a row of N storage columns. A key offered at the insert port enters the leftmost column. It travels rightward through every column in the same clock. At each occupied column it is compared with the resident key. The smaller of the two stays, and the larger continues to the right. The key therefore settles in its sorted slot, and every resident key at or above it moves one column to the right.

Each column holds one key and an occupancy flag that is 1 when the column is empty. The column makes its decision with a one-bit comparator chain that runs from the least to the most significant bit. A clear input marks every column empty. A read command moves every key and flag one column to the left, so the smallest key leaves first at the output port. The full and empty flags tell the caller when an insert or a read is useful.

Top module: `ss_insert_sorter`

## Requirements
- R1: After reset or a clear pulse, `empty` is 1, `full` is 0 and `out_valid` is 0.
- R2: A series of reads returns the stored keys in non-decreasing order, smallest first, with each read removing exactly one key.
- R3: Keys of equal value are all kept and each is returned by its own read.
- R4: An insert while `full` is 1 is ignored, and the stored list and `out_key` are unchanged.
- R5: A read while `empty` is 1 has no effect, and `out_valid` stays 0.
- R6: When `ins_valid` and `rd_req` are both 1, only the insert takes place and no key is removed.
- R7: While a key is stored, `out_valid` is 1 and `out_key` equals the smallest stored key.
- R8: `full` is 1 exactly when N keys are stored, and `empty` is 1 exactly when none is stored.
- R9: Keys compare as unsigned numbers. A key with its top bit set sorts above every key with that bit clear.
- R10: A clear takes priority over an insert or a read issued in the same cycle. The array ends up empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; empties all columns |
| clr | input | 1 | Synchronous clear of the whole list |
| ins_valid | input | 1 | Insert `ins_key` this cycle |
| ins_key | input | W | Key to insert, unsigned |
| rd_req | input | 1 | Remove the key shown at `out_key` |
| full | output | 1 | All N columns hold a key |
| empty | output | 1 | No column holds a key |
| out_valid | output | 1 | `out_key` holds a stored key |
| out_key | output | W | Smallest stored key (leftmost column) |

## Verification
The checker treats clear, insert and read as a priority-ordered set of requests. It does not assume they are exclusive, because the design resolves any overlap. The checker keeps its own occupancy count from the accepted requests. It relates `full` and `empty` to that count, and it relates successive read outputs to each other. The stimulus changes inputs only just after a rising edge. It drives the overlapping cases on purpose: an insert together with a read, an insert together with a clear, an insert while full and a read while empty. It also uses ascending, descending, duplicate and top-bit-set key patterns. These keep every accepted request within the rules the checker models.

// File: rtl/ss_sorter_pkg.sv
package ss_sorter_pkg;

   // Array-wide action chosen once per cycle; the order of checks sets priority.
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_WIPE  = 2'd1,
      ACT_PLACE = 2'd2,
      ACT_SHIFT = 2'd3
   } act_e;

   function automatic act_e pick_action(input logic clr,
                                        input logic ins,
                                        input logic rd,
                                        input logic is_full,
                                        input logic is_empty);
      if (clr)
         return ACT_WIPE;
      else if (ins)
         return is_full ? ACT_HOLD : ACT_PLACE;
      else if (rd)
         return is_empty ? ACT_HOLD : ACT_SHIFT;
      else
         return ACT_HOLD;
   endfunction

endpackage

// File: rtl/ss_bit_cmp.sv
// One bit stage of the column comparator, chained from LSB to MSB.
// Result: resident key is strictly less than the arriving key so far.
module ss_bit_cmp (
   input  logic arr_bit,
   input  logic res_bit,
   input  logic lt_in,
   output logic lt_out
);
   always_comb begin
      if (arr_bit == res_bit)
         lt_out = lt_in;
      else
         lt_out = arr_bit;
   end
endmodule

// File: rtl/ss_column.sv
module ss_column
   import ss_sorter_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  act_e         act,
   input  logic [W-1:0] arr_key,
   input  logic         arr_vld,
   input  logic [W-1:0] nbr_key,
   input  logic         nbr_vacant,
   output logic [W-1:0] res_key,
   output logic         res_vacant,
   output logic [W-1:0] pass_key,
   output logic         pass_vld
);

   initial begin
      if (W < 1) $error("ss_column: W must be at least 1");
   end

   logic [W:0] lt_chain;
   logic       res_lt;

   // Seed 0: equal keys count as not-less, so the arriving key is kept.
   assign lt_chain[0] = 1'b0;

   for (genvar b = 0; b < W; b++) begin : g_bit
      ss_bit_cmp i_bit (
         .arr_bit (arr_key[b]),
         .res_bit (res_key[b]),
         .lt_in   (lt_chain[b]),
         .lt_out  (lt_chain[b+1])
      );
   end

   assign res_lt = lt_chain[W];

   // A vacant column absorbs the arrival; an occupied one forwards the larger key.
   always_comb begin
      pass_vld = arr_vld && !res_vacant;
      pass_key = res_lt ? arr_key : res_key;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_key    <= '0;
         res_vacant <= 1'b1;
      end else begin
         unique case (act)
            ACT_WIPE: begin
               res_vacant <= 1'b1;
            end
            ACT_PLACE: begin
               if (arr_vld) begin
                  if (res_vacant || !res_lt)
                     res_key <= arr_key;
                  res_vacant <= 1'b0;
               end
            end
            ACT_SHIFT: begin
               res_key    <= nbr_key;
               res_vacant <= nbr_vacant;
            end
            default: begin
            end
         endcase
      end
   end

endmodule

// File: rtl/ss_insert_sorter.sv
module ss_insert_sorter
   import ss_sorter_pkg::*;
#(
   parameter int W = 8,
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ins_valid,
   input  logic [W-1:0] ins_key,
   input  logic         rd_req,
   output logic         full,
   output logic         empty,
   output logic         out_valid,
   output logic [W-1:0] out_key
);

   localparam int LAST = N - 1;

   initial begin
      if (W < 1) $error("ss_insert_sorter: W must be at least 1");
      if (N < 2) $error("ss_insert_sorter: N must be at least 2");
   end

   act_e         act;
   logic [W-1:0] col_key    [N];
   logic         col_vacant [N];
   logic [W-1:0] link_key   [N+1];
   logic         link_vld   [N+1];
   logic [W-1:0] nbr_key    [N];
   logic         nbr_vacant [N];

   assign link_key[0] = ins_key;
   assign link_vld[0] = 1'b1;

   for (genvar c = 0; c < N; c++) begin : g_col
      if (c == LAST) begin : g_edge
         // Rightmost column refills with the vacant state on a shift.
         assign nbr_key[c]    = '0;
         assign nbr_vacant[c] = 1'b1;
      end else begin : g_inner
         assign nbr_key[c]    = col_key[c+1];
         assign nbr_vacant[c] = col_vacant[c+1];
      end

      ss_column #(.W(W)) i_col (
         .clk        (clk),
         .rst_n      (rst_n),
         .act        (act),
         .arr_key    (link_key[c]),
         .arr_vld    (link_vld[c]),
         .nbr_key    (nbr_key[c]),
         .nbr_vacant (nbr_vacant[c]),
         .res_key    (col_key[c]),
         .res_vacant (col_vacant[c]),
         .pass_key   (link_key[c+1]),
         .pass_vld   (link_vld[c+1])
      );
   end

   // Occupancy fills from the left, so the end columns give the status.
   assign empty     = col_vacant[0];
   assign full      = !col_vacant[LAST];
   assign out_valid = !col_vacant[0];
   assign out_key   = col_key[0];

   assign act = pick_action(clr, ins_valid, rd_req, full, empty);

endmodule

// File: rtl/ss_insert_sorter_chk.sv
module ss_insert_sorter_chk #(
   parameter int W = 8,
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic         ins_valid,
   input logic [W-1:0] ins_key,
   input logic         rd_req,
   input logic         full,
   input logic         empty,
   input logic         out_valid,
   input logic [W-1:0] out_key
);
   localparam int CW = $clog2(N + 1);

   logic [CW-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= '0;
      else if (clr)
         held <= '0;
      else if (ins_valid) begin
         if (held != CW'(N)) held <= held + 1'b1;
      end else if (rd_req) begin
         if (held != '0) held <= held - 1'b1;
      end
   end

   // R1
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !full && !out_valid));

   // R8
   full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full == (held == CW'(N)));

   // R8
   empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (held == '0));

   // R4
   full_insert_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ins_valid && !clr) |=> (full && $stable(out_key)));

   // R5
   empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_req && !ins_valid && !clr) |=> (empty && !out_valid));

   // R2
   read_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && rd_req && !ins_valid && !clr) |=> (!out_valid || out_key >= $past(out_key)));

   // R6
   insert_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && rd_req && !clr && !full) |=> !empty);

endmodule

bind ss_insert_sorter ss_insert_sorter_chk #(.W(W), .N(N)) i_chk (.*);

// File: tb/test_ss_insert_sorter.sv
`timescale 1ns/1ps
module test_ss_insert_sorter;
   localparam int W = 8;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0;
   logic         ins_valid = 1'b0;
   logic [W-1:0] ins_key = '0;
   logic         rd_req = 1'b0;
   logic         full, empty, out_valid;
   logic [W-1:0] out_key;

   int checks = 0;
   int failures = 0;
   int model[$];
   bit done = 0;

   always #2 clk = ~clk;

   ss_insert_sorter #(.W(W), .N(N)) i_ss_insert_sorter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ins_valid(ins_valid),
      .ins_key(ins_key), .rd_req(rd_req), .full(full), .empty(empty),
      .out_valid(out_valid), .out_key(out_key)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference: place before the first stored key that is >= the new one.
   task automatic model_put(input int k);
      int pos;
      if (model.size() >= N) return;
      pos = model.size();
      for (int i = 0; i < model.size(); i++)
         if (model[i] >= k) begin pos = i; break; end
      model.insert(pos, k);
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic put(input int k);
      ins_valid = 1'b1; ins_key = W'(k);
      model_put(k);
      step();
      ins_valid = 1'b0;
   endtask

   task automatic take();
      rd_req = 1'b1;
      step();
      rd_req = 1'b0;
   endtask

   task automatic drain();
      int n = model.size();
      for (int i = 0; i < n; i++) take();
   endtask

   // Monitor: a pure read is compared against the reference head and consumes it.
   always @(negedge clk) begin
      if (rst_n && rd_req && !ins_valid && !clr) begin
         if (model.size() == 0) begin
            check(!out_valid, "R5", int'(out_valid), 0);
         end else begin
            check(out_valid, "R7", int'(out_valid), 1);
            check(int'(out_key) == model[0], "R2", int'(out_key), model[0]);
            void'(model.pop_front());
         end
      end
   end

   task automatic status(input string req);
      @(negedge clk);
      check(empty == (model.size() == 0), req, int'(empty), int'(model.size() == 0));
      check(full == (model.size() == N), req, int'(full), int'(model.size() == N));
      step();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset state
      @(negedge clk);
      check(empty && !full && !out_valid, "R1", {empty, full, out_valid}, 3'b100);
      step();

      // R2 mixed pattern
      put(42); put(7); put(99); put(7 + 13); put(3);
      @(negedge clk);
      check(out_valid && out_key == 3, "R7", int'(out_key), 3);
      step();
      drain();
      status("R8");

      // R3 duplicates
      put(3); put(3); put(3); put(1); put(3);
      drain();

      // R8 fill with descending keys, R4 insert while full
      for (int i = 0; i < N; i++) put(200 - 10 * i);
      status("R8");
      put(0);
      @(negedge clk);
      check(full && out_key == model[0], "R4", int'(out_key), model[0]);
      step();
      drain();
      status("R8");

      // R5 read while empty
      take(); take();
      status("R5");

      // R9 unsigned ordering
      put(200); put(1); put(128); put(127); put(255); put(0);
      drain();

      // R6 insert and read together
      put(50);
      ins_valid = 1'b1; rd_req = 1'b1; ins_key = 8'd10; model_put(10);
      step();
      ins_valid = 1'b0; rd_req = 1'b0;
      @(negedge clk);
      check(out_key == 10 && model.size() == 2, "R6", int'(out_key), 10);
      step();
      drain();

      // R10 clear beats insert
      put(5); put(6);
      clr = 1'b1; ins_valid = 1'b1; ins_key = 8'd9;
      step();
      clr = 1'b0; ins_valid = 1'b0;
      model.delete();
      @(negedge clk);
      check(empty && !out_valid, "R10", int'(empty), 1);
      step();

      // R1 clear of a partly filled list, then ascending refill
      for (int i = 0; i < 4; i++) put(i * 20);
      clr = 1'b1; step(); clr = 1'b0;
      model.delete();
      status("R1");
      for (int i = 0; i < N; i++) put(i + 1);
      status("R8");
      drain();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule